// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master peripheral that a host CPU drives through six 32-bit registers. One write to the transmit register starts a full-duplex exchange of one 8-bit word. The block shifts the word out on the data output, most significant bit first, and captures eight bits from the data input into the receive register. Status flags report the end of the exchange. Software then reads the received byte and can start the next exchange.

The serial clock comes from two divider stages. A control bit selects a coarse stage of 16 or 128. A 5-bit field N then sets a further even division of (N+1)*2. Clock polarity and phase are set per transfer. The chip-select output is a plain level that software writes in the system-control register. Nothing in the block changes it on its own.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` and `mosi` are 0, and the control register (offset 0x00) and the status register (offset 0x04) read as 0.
- R2: The control register (0x00), the system-control register (0x08) and the second control register (0x14) read back their last written low 8 bits. The transmit register (0x0C) reads back the last byte accepted for transmission.
- R3: Control bits [4:0] hold N, and control bit 5 selects the coarse divider: 0 selects 16, 1 selects 128. Each half period of `sclk` lasts divider*(N+1) clock cycles. An exchange consists of 16 half periods, the first of which begins at the write that starts it.
- R4: Control bit 6 is the clock polarity: `sclk` rests at that level outside an exchange. Control bit 7 is the phase. With phase 0 the input is sampled on the leading (odd-numbered) clock edges. With phase 1 it is sampled on the trailing (even-numbered) clock edges.
- R5: Data leaves MSB first, and each output bit is stable at the edge where the slave samples it. After the exchange, `mosi` holds the last bit sent (bit 0).
- R6: Status bit 0 reads as 1 from the cycle after an accepted transmit write until the 16th clock edge, and reads as 0 otherwise.
- R7: At the 16th edge, status bit 2 becomes 1 and bits [7:0] of the receive register (0x10) hold the 8 bits sampled, first sample in bit 7.
- R8: A read of the receive register with `rd_en` clears status bit 2. So does a write to the status register with bit 2 of the written data at 0.
- R9: A write to the transmit register while status bit 0 is 1 is ignored. The exchange in progress, the received byte and the transmit register readback stay unchanged.
- R10: `cs_n` equals bit 6 of the system-control register. The reset value is 1, and writing 0x21 drives `cs_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench takes the clock edge that captures the transmit write as cycle 0. The k-th serial clock edge (k from 0) is then due (k+1)*H cycles later, where H is divider*(N+1). The busy flag drops, the receive flag rises and the receive byte appears on that same 16th edge, at cycle 16*H. The bench counts exactly H rising clock edges per half period. It then checks `sclk`, `mosi`, and the status seen through the combinational read port on the following falling edge. Its slave model changes `miso` at least half a period before each sampling edge. The bench sweeps every mode, several data patterns and every N from 0 to 7, and adds the extreme divider settings.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);
  localparam int HALF_W = $clog2(PRE_HI * 32) + 1;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam logic [AW-1:0] A_SYS   = AW'(8);
  localparam logic [AW-1:0] A_TX    = AW'(12);
  localparam logic [AW-1:0] A_RX    = AW'(16);
  localparam logic [AW-1:0] A_CTRL2 = AW'(20);

  logic [7:0] ctrl, sysctl, ctrl2, txbuf, rxbuf, txsh, rxsh;
  logic busy, rx_full, ph, mosi_q;
  logic [3:0] edg;
  logic [HALF_W-1:0] half_q, cnt, half_next;

  assign half_next = HALF_W'(ctrl[5] ? PRE_HI : PRE_LO) * HALF_W'({1'b0, ctrl[4:0]} + 6'd1);

  wire cpha  = ctrl[7];
  wire wr_tx = wr_en && addr == A_TX && !busy;
  wire tick  = busy && cnt == half_q - HALF_W'(1);
  wire smp   = tick && (edg[0] == cpha);
  wire shf   = tick && (edg[0] != cpha) && !(!cpha && edg == 4'd15);
  wire last  = tick && edg == 4'd15;
  wire [7:0] rx_next = {rxsh[6:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; sysctl <= 8'h40; ctrl2 <= '0;
      txbuf <= '0; rxbuf <= '0; txsh <= '0; rxsh <= '0;
      busy <= 1'b0; rx_full <= 1'b0; ph <= 1'b0; mosi_q <= 1'b0;
      edg <= '0; cnt <= '0; half_q <= '0;
    end else begin
      if (wr_en && addr == A_CTRL)  ctrl   <= wdata[7:0];
      if (wr_en && addr == A_SYS)   sysctl <= wdata[7:0];
      if (wr_en && addr == A_CTRL2) ctrl2  <= wdata[7:0];
      if (wr_tx) begin
        txbuf  <= wdata[7:0];
        busy   <= 1'b1;
        cnt    <= '0;
        edg    <= '0;
        ph     <= 1'b0;
        half_q <= half_next;
        if (!cpha) begin
          mosi_q <= wdata[7];
          txsh   <= {wdata[6:0], 1'b0};
        end else begin
          txsh   <= wdata[7:0];
        end
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + HALF_W'(1);
        if (tick) begin
          ph  <= ~ph;
          edg <= edg + 4'd1;
        end
        if (smp) rxsh <= rx_next;
        if (shf) begin
          mosi_q <= txsh[7];
          txsh   <= {txsh[6:0], 1'b0};
        end
        if (last) begin
          busy  <= 1'b0;
          rxbuf <= smp ? rx_next : rxsh;
        end
      end
      if (last)
        rx_full <= 1'b1;
      else if ((rd_en && addr == A_RX) || (wr_en && addr == A_STAT && !wdata[2]))
        rx_full <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {24'b0, ctrl};
      A_STAT:  rdata = {29'b0, rx_full, 1'b0, busy};
      A_SYS:   rdata = {24'b0, sysctl};
      A_TX:    rdata = {24'b0, txbuf};
      A_RX:    rdata = {24'b0, rxbuf};
      A_CTRL2: rdata = {24'b0, ctrl2};
      default: rdata = '0;
    endcase
  end

  assign sclk = ctrl[6] ^ ph;
  assign mosi = mosi_q;
  assign cs_n = sysctl[6];
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          busy,
  input logic          rx_full,
  input logic          sclk,
  input logic          cpol,
  input logic          mosi,
  input logic          cs_n,
  input logic [7:0]    txbuf
);
  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

  assert_cs_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8)) |=> cs_n == $past(wdata[6]));

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12) && !busy) |=> busy);

  assert_rx_full_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_full);

  assert_tx_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == AW'(12)) |=> $stable(txbuf));

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(mosi));
endmodule

bind spi_byte_master spi_byte_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .rx_full(rx_full), .sclk(sclk), .cpol(ctrl[6]),
  .mosi(mosi), .cs_n(cs_n), .txbuf(txbuf)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, cs_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pop(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit sel, input logic [4:0] n,
                      input logic [7:0] tb, input logic [7:0] sb,
                      input bit intrude, input bit clr_by_status);
    int half;
    logic [31:0] v;
    half = (sel ? 128 : 16) * (int'(n) + 1);
    wr(5'h00, {24'b0, cpha, cpol, sel, n});
    chk(sclk == cpol, "R4 idle sclk", 32'(sclk), 32'(cpol));
    wr(5'h0C, {24'b0, tb});
    peek(5'h04, v);
    chk(v[0] == 1'b1, "R6 busy after start", v, 32'h1);
    for (int k = 0; k < 16; k++) begin
      if ((k % 2) == int'(cpha)) miso = sb[7 - k/2];
      if (intrude && k == 3) begin
        addr = 5'h0C; wdata = {24'b0, ~tb}; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        repeat (half - 1) @(posedge clk);
      end else begin
        repeat (half) @(posedge clk);
      end
      @(negedge clk);
      chk(sclk == (cpol ^ ((k % 2) == 0)), "R3 sclk edge timing", 32'(sclk), 32'(cpol ^ ((k % 2) == 0)));
      if ((k % 2) == int'(cpha))
        chk(mosi == tb[7 - k/2], "R5 mosi bit at sample edge", 32'(mosi), 32'(tb[7 - k/2]));
      if (k == 14) begin
        peek(5'h04, v);
        chk(v[0] == 1'b1, "R6 busy before last edge", v, 32'h1);
      end
    end
    peek(5'h04, v);
    chk(v == 32'h4, "R7 status after exchange", v, 32'h4);
    chk(mosi == tb[0], "R5 mosi holds last bit", 32'(mosi), 32'(tb[0]));
    peek(5'h0C, v);
    chk(v == {24'b0, tb}, intrude ? "R9 tx write ignored" : "R2 tx readback", v, {24'b0, tb});
    if (clr_by_status) begin
      wr(5'h04, 32'h0);
      peek(5'h04, v);
      chk(v == 32'h0, "R8 status write clears", v, 32'h0);
      peek(5'h10, v);
      chk(v == {24'b0, sb}, "R7 rx byte", v, {24'b0, sb});
    end else begin
      pop(5'h10, v);
      chk(v == {24'b0, sb}, "R7 rx byte", v, {24'b0, sb});
      peek(5'h04, v);
      chk(v == 32'h0, "R8 rx read clears", v, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n reset", 32'(cs_n), 32'h1);
    chk(sclk == 1'b0, "R1 sclk reset", 32'(sclk), 32'h0);
    chk(mosi == 1'b0, "R1 mosi reset", 32'(mosi), 32'h0);
    rst_n = 1'b1;
    peek(5'h00, v); chk(v == 32'h0, "R1 ctrl reset", v, 32'h0);
    peek(5'h04, v); chk(v == 32'h0, "R1 status reset", v, 32'h0);

    wr(5'h08, 32'h21);
    chk(cs_n == 1'b0, "R10 cs low", 32'(cs_n), 32'h0);
    peek(5'h08, v); chk(v == 32'h21, "R2 sysctl readback", v, 32'h21);
    wr(5'h14, 32'h5);
    peek(5'h14, v); chk(v == 32'h5, "R2 ctrl2 readback", v, 32'h5);

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 4; i++) begin
        logic [7:0] tb;
        tb = 8'(8'h5A + m * 8'h33 + i * 8'h47);
        xfer(m[0], m[1], 1'b0, 5'd0, tb, ~tb ^ 8'h0F, 1'b0, 1'b0);
      end
    for (int n = 0; n < 8; n++)
      xfer(1'b0, 1'b0, 1'b0, 5'(n), 8'(8'h81 + n * 8'h1D), 8'(8'hC3 ^ n * 8'h11), 1'b0, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 5'd0, 8'h96, 8'h69, 1'b0, 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 5'd1, 8'h01, 8'h80, 1'b0, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 5'd31, 8'hF0, 8'h0F, 1'b0, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 5'd0, 8'hB4, 8'h2D, 1'b1, 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 5'd1, 8'h3E, 8'hE3, 1'b0, 1'b1);

    wr(5'h08, 32'h61);
    chk(cs_n == 1'b1, "R10 cs high", 32'(cs_n), 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule